// File: doc/BRIEF.md
# Carrier Acquisition and Slip Supervisor

This block sequences carrier acquisition in a coherent receiver and watches the tracking loop for cycle slips. It does no loop arithmetic itself. On a start command it turns on the coarse frequency discriminator and waits for its result. It then spends one cycle loading that estimate into the fine loop's frequency integrator. After that it enables the fine loop and counts symbols until the phase error has stayed small long enough to call the loop locked. If the fine loop fails to settle within a programmable number of symbols, control goes back to the coarse stage.

While locked, the block compares the loop integrator value at each symbol with the value at the previous symbol. A jump larger than half a turn (π) is a cycle slip. A slip drops lock, emits a one-cycle slip pulse, and sends the sequence back through coarse acquisition. The slip pulse tells the fine loop to clear its state, and it lets downstream phase-ambiguity logic react to the constellation rotation. A saturating counter records how many slips have occurred.

Top module: `carrier_acq_supervisor`

## Requirements
- R1: While reset is asserted, and until the first start after it, every output is 0: both enables, the load strobe, locked, the slip pulse and the slip count.
- R2: A start pulse seen while idle makes coarse_en_o go high on the next cycle. A start pulse seen in any other state is ignored.
- R3: A coarse_done_i pulse seen while coarse_en_o is high captures coarse_est_i. On the next cycle fine_load_o is high for exactly one cycle, coarse_en_o is low, and fine_load_val_o carries the captured value. coarse_done_i is ignored at any other time.
- R4: fine_en_o rises on the cycle after the load cycle and stays high during fine acquisition and tracking. At most one of coarse_en_o, fine_load_o, fine_en_o and slip_o is high in any cycle.
- R5: During fine acquisition, a symbol is good when the magnitude of the two's-complement phase_err_i is strictly below the unsigned lock_thr_i. locked_o rises on the cycle after the 32nd consecutive good symbol. Any symbol that is not good restarts the run. The most negative code has magnitude 2^(PH_W-1).
- R6: If the N-th symbol of fine acquisition (N = effective timeout) arrives without lock, the next cycle returns to coarse acquisition. If lock and timeout fall on the same symbol, lock wins.
- R7: lock_timeout_i = 0 selects the default timeout of 200 symbols. Any other value is used as given.
- R8: While locked, a symbol whose loop_int_i differs from the value sampled at the previous symbol by strictly more than PI_LSB (either sign) causes a slip. On the next cycle slip_o is high for one cycle and locked_o is low, and on the cycle after that coarse_en_o is high. A difference of exactly PI_LSB is not a slip. The integrator is sampled at every symbol of fine acquisition and tracking.
- R9: slip_cnt_o increments by one for each slip, with the new value visible in the same cycle as slip_o. It holds at its all-ones value instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start acquisition (honoured only when idle) |
| sym_stb_i | input | 1 | One-cycle symbol strobe |
| coarse_done_i | input | 1 | Coarse discriminator result valid |
| coarse_est_i | input | INT_W | Coarse frequency estimate |
| loop_int_i | input | INT_W | Fine loop integrator value, signed |
| phase_err_i | input | PH_W | Fine loop phase error, signed |
| lock_thr_i | input | PH_W | Lock threshold on phase error magnitude, unsigned |
| lock_timeout_i | input | TO_W | Lock timeout in symbols, 0 selects default |
| coarse_en_o | output | 1 | Coarse discriminator enable |
| fine_load_o | output | 1 | Load strobe for the fine frequency integrator |
| fine_load_val_o | output | INT_W | Value to load into the fine integrator |
| fine_en_o | output | 1 | Fine loop enable |
| locked_o | output | 1 | Carrier lock flag |
| slip_o | output | 1 | One-cycle slip pulse, also clears the fine loop |
| slip_cnt_o | output | CNT_W | Saturating slip count |

## Verification
The bench targets these boundary cases:
- A phase error equal to the threshold, and the most negative phase error code. A design that used less-or-equal, or mishandled that code, would lock too early.
- A bad symbol in the middle of a run. An off-by-one in the run counter would move the lock cycle.
- An integrator step of exactly π in both directions, which must not slip, next to π plus one LSB, which must. A design that compared with greater-or-equal or ignored the sign would slip falsely or miss the slip.
- A timeout equal to the lock length, where lock must win. The default of 200 symbols selected by a zero setting.
- A slip counter driven past all-ones, which must hold rather than wrap to zero.
- Start and done pulses outside their states, which a loose state machine would act on.

// File: rtl/cars_pkg.sv
package cars_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_COARSE   = 3'd1,
    ST_HANDOFF  = 3'd2,
    ST_FINE_ACQ = 3'd3,
    ST_TRACK    = 3'd4,
    ST_REACQ    = 3'd5
  } cars_state_e;

endpackage

// File: rtl/cars_rst_sync.sv
module cars_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;

endmodule

// File: rtl/cars_lock_monitor.sv
module cars_lock_monitor #(
  parameter int PH_W        = 16,
  parameter int TO_W        = 16,
  parameter int LOCK_N      = 32,
  parameter int DEF_TIMEOUT = 200
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            active_i,
  input  logic            sym_stb_i,
  input  logic [PH_W-1:0] phase_err_i,
  input  logic [PH_W-1:0] thr_i,
  input  logic [TO_W-1:0] timeout_i,
  output logic            lock_hit_o,
  output logic            timeout_hit_o
);

  localparam int GC_W = $clog2(LOCK_N + 1);

  logic [GC_W-1:0] good_q, good_d;
  logic [TO_W-1:0] sym_q, sym_d;
  logic [PH_W-1:0] err_mag;
  logic            good_sym;
  logic [TO_W-1:0] eff_to;
  logic [TO_W:0]   sym_inc;
  logic            stb_act;

  // magnitude of two's complement error; most negative code maps to 2^(PH_W-1)
  assign err_mag  = phase_err_i[PH_W-1] ? (~phase_err_i + PH_W'(1)) : phase_err_i;
  assign good_sym = (err_mag < thr_i);
  assign eff_to   = (timeout_i == '0) ? TO_W'(DEF_TIMEOUT) : timeout_i;
  assign sym_inc  = {1'b0, sym_q} + (TO_W+1)'(1);
  assign stb_act  = active_i && sym_stb_i;

  assign lock_hit_o    = stb_act && good_sym && (good_q == GC_W'(LOCK_N - 1));
  assign timeout_hit_o = stb_act && (sym_inc >= {1'b0, eff_to});

  always_comb begin
    good_d = good_q;
    sym_d  = sym_q;
    if (!active_i || lock_hit_o || timeout_hit_o) begin
      good_d = '0;
      sym_d  = '0;
    end else if (sym_stb_i) begin
      good_d = good_sym ? (good_q + GC_W'(1)) : '0;
      sym_d  = sym_inc[TO_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      good_q <= '0;
      sym_q  <= '0;
    end else begin
      good_q <= good_d;
      sym_q  <= sym_d;
    end
  end

  // R5: the good-symbol run never reaches the lock length while held
  a_r5_good_bound: assert property (@(posedge clk) disable iff (!rst_n)
    good_q < GC_W'(LOCK_N));

  // R5: a symbol at or above threshold restarts the run
  a_r5_bad_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && sym_stb_i && !good_sym) |=> (good_q == '0));

endmodule

// File: rtl/cars_slip_detect.sv
module cars_slip_detect #(
  parameter int INT_W  = 20,
  parameter int PI_LSB = 32768
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_i,
  input  logic             check_i,
  input  logic [INT_W-1:0] loop_int_i,
  output logic             slip_hit_o
);

  logic [INT_W-1:0] prev_q;
  logic [INT_W:0]   diff;
  logic [INT_W:0]   diff_mag;

  assign diff     = {loop_int_i[INT_W-1], loop_int_i} - {prev_q[INT_W-1], prev_q};
  assign diff_mag = diff[INT_W] ? (~diff + (INT_W+1)'(1)) : diff;

  assign slip_hit_o = sample_i && check_i && (diff_mag > (INT_W+1)'(PI_LSB));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
    end else if (sample_i) begin
      prev_q <= loop_int_i;
    end
  end

  // R8: the reference sample follows the integrator at every sampled symbol
  a_r8_prev_follows: assert property (@(posedge clk) disable iff (!rst_n)
    sample_i |=> (prev_q == $past(loop_int_i)));

endmodule

// File: rtl/cars_sat_counter.sv
module cars_sat_counter #(
  parameter int W        = 16,
  parameter bit SATURATE = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         at_max;

  generate
    if (SATURATE) begin : g_sat
      assign at_max = &cnt_q;
      assign cnt_d  = (inc_i && !at_max) ? (cnt_q + W'(1)) : cnt_q;
    end else begin : g_wrap
      assign at_max = 1'b0;
      assign cnt_d  = inc_i ? (cnt_q + W'(1)) : cnt_q;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

  // R9: the count only ever moves up by one
  a_r9_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q)) |-> (cnt_q == $past(cnt_q) + W'(1)));

  // R9: all-ones is sticky when saturating
  a_r9_hold_max: assert property (@(posedge clk) disable iff (!rst_n)
    (SATURATE && ($past(cnt_q) == {W{1'b1}})) |-> (cnt_q == {W{1'b1}}));

endmodule

// File: rtl/carrier_acq_supervisor.sv
module carrier_acq_supervisor
  import cars_pkg::*;
#(
  parameter int INT_W       = 20,
  parameter int PH_W        = 16,
  parameter int TO_W        = 16,
  parameter int CNT_W       = 16,
  parameter int LOCK_N      = 32,
  parameter int DEF_TIMEOUT = 200,
  parameter int PI_LSB      = 32768
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             sym_stb_i,
  input  logic             coarse_done_i,
  input  logic [INT_W-1:0] coarse_est_i,
  input  logic [INT_W-1:0] loop_int_i,
  input  logic [PH_W-1:0]  phase_err_i,
  input  logic [PH_W-1:0]  lock_thr_i,
  input  logic [TO_W-1:0]  lock_timeout_i,
  output logic             coarse_en_o,
  output logic             fine_load_o,
  output logic [INT_W-1:0] fine_load_val_o,
  output logic             fine_en_o,
  output logic             locked_o,
  output logic             slip_o,
  output logic [CNT_W-1:0] slip_cnt_o
);

  logic             rst_s_n;
  cars_state_e      st_q, st_d;
  logic [INT_W-1:0] est_q;
  logic             est_en;
  logic             cnt_inc;
  logic             lock_hit;
  logic             timeout_hit;
  logic             slip_hit;
  logic             in_fine;
  logic             in_track;

  cars_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  assign in_fine  = (st_q == ST_FINE_ACQ);
  assign in_track = (st_q == ST_TRACK);

  cars_lock_monitor #(
    .PH_W        (PH_W),
    .TO_W        (TO_W),
    .LOCK_N      (LOCK_N),
    .DEF_TIMEOUT (DEF_TIMEOUT)
  ) u_lock_mon (
    .clk           (clk),
    .rst_n         (rst_s_n),
    .active_i      (in_fine),
    .sym_stb_i     (sym_stb_i),
    .phase_err_i   (phase_err_i),
    .thr_i         (lock_thr_i),
    .timeout_i     (lock_timeout_i),
    .lock_hit_o    (lock_hit),
    .timeout_hit_o (timeout_hit)
  );

  cars_slip_detect #(
    .INT_W  (INT_W),
    .PI_LSB (PI_LSB)
  ) u_slip_det (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .sample_i   (sym_stb_i && (in_fine || in_track)),
    .check_i    (in_track),
    .loop_int_i (loop_int_i),
    .slip_hit_o (slip_hit)
  );

  cars_sat_counter #(
    .W        (CNT_W),
    .SATURATE (1'b1)
  ) u_slip_cnt (
    .clk   (clk),
    .rst_n (rst_s_n),
    .inc_i (cnt_inc),
    .cnt_o (slip_cnt_o)
  );

  // next-state decode
  always_comb begin
    st_d    = st_q;
    est_en  = 1'b0;
    cnt_inc = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start_i) st_d = ST_COARSE;
      end
      ST_COARSE: begin
        if (coarse_done_i) begin
          est_en = 1'b1;
          st_d   = ST_HANDOFF;
        end
      end
      ST_HANDOFF: begin
        st_d = ST_FINE_ACQ;
      end
      ST_FINE_ACQ: begin
        if (lock_hit)         st_d = ST_TRACK;
        else if (timeout_hit) st_d = ST_COARSE;
      end
      ST_TRACK: begin
        if (slip_hit) begin
          st_d    = ST_REACQ;
          cnt_inc = 1'b1;
        end
      end
      ST_REACQ: begin
        st_d = ST_COARSE;
      end
      default: begin
        st_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      est_q <= '0;
    end else if (est_en) begin
      est_q <= coarse_est_i;
    end
  end

  assign coarse_en_o     = (st_q == ST_COARSE);
  assign fine_load_o     = (st_q == ST_HANDOFF);
  assign fine_load_val_o = est_q;
  assign fine_en_o       = in_fine || in_track;
  assign locked_o        = in_track;
  assign slip_o          = (st_q == ST_REACQ);

  // R3: the load strobe lasts one cycle and hands over to the fine loop
  a_r3_load_single: assert property (@(posedge clk) disable iff (!rst_s_n)
    fine_load_o |=> (!fine_load_o && fine_en_o));

  // R3: a load is only reached from coarse acquisition
  a_r3_load_after_coarse: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(fine_load_o) |-> $past(coarse_en_o));

  // R4: the sequencing outputs never overlap
  a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_s_n)
    $onehot0({coarse_en_o, fine_load_o, fine_en_o, slip_o}));

  // R5: lock is only declared out of fine acquisition on a symbol
  a_r5_lock_entry: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(locked_o) |-> ($past(fine_en_o) && $past(sym_stb_i)));

  // R8: a slip comes only out of lock on a symbol and clears lock
  a_r8_slip_from_lock: assert property (@(posedge clk) disable iff (!rst_s_n)
    slip_o |-> (!locked_o && $past(locked_o) && $past(sym_stb_i)));

  // R8: after the slip pulse coarse acquisition restarts
  a_r8_slip_reacquire: assert property (@(posedge clk) disable iff (!rst_s_n)
    slip_o |=> coarse_en_o);

endmodule

// File: tb/tb_carrier_acq_supervisor.sv
module tb_carrier_acq_supervisor;

  localparam int INT_W = 20;
  localparam int PH_W  = 16;
  localparam int TO_W  = 16;
  localparam int CNT_W = 4;
  localparam int LOCKN = 32;
  localparam int PI    = 32768;
  localparam int CMAX  = (1 << CNT_W) - 1;

  localparam int S_IDLE = 0, S_CO = 1, S_HO = 2, S_FI = 3, S_TR = 4, S_RE = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, done = 1'b0, stb = 1'b0;
  logic [INT_W-1:0] est = '0;
  logic signed [INT_W-1:0] li = '0;
  logic signed [PH_W-1:0]  pe = '0;
  logic [PH_W-1:0] thr = 16'd100;
  logic [TO_W-1:0] tmo = '0;

  logic             coarse_en, fine_load, fine_en, locked, slip;
  logic [INT_W-1:0] load_val;
  logic [CNT_W-1:0] slip_cnt;

  always #5 clk = ~clk;

  carrier_acq_supervisor #(
    .INT_W (INT_W), .PH_W (PH_W), .TO_W (TO_W), .CNT_W (CNT_W),
    .LOCK_N (LOCKN), .DEF_TIMEOUT (200), .PI_LSB (PI)
  ) dut (
    .clk (clk), .rst_n (rst_n), .start_i (start), .sym_stb_i (stb),
    .coarse_done_i (done), .coarse_est_i (est), .loop_int_i (li),
    .phase_err_i (pe), .lock_thr_i (thr), .lock_timeout_i (tmo),
    .coarse_en_o (coarse_en), .fine_load_o (fine_load),
    .fine_load_val_o (load_val), .fine_en_o (fine_en), .locked_o (locked),
    .slip_o (slip), .slip_cnt_o (slip_cnt)
  );

  int nvec = 0;
  int nfail = 0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // behavioural reference model
  int         m_st, m_good, m_sym, m_cnt;
  longint     m_prev;
  logic [INT_W-1:0] m_est;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = S_IDLE; m_good = 0; m_sym = 0; m_cnt = 0; m_prev = 0; m_est = '0;
    end else begin
      int     nst, mag, eff;
      longint d;
      bit     smp;
      nst = m_st;
      smp = stb && (m_st == S_FI || m_st == S_TR);
      case (m_st)
        S_IDLE: if (start) nst = S_CO;
        S_CO:   if (done) begin m_est = est; nst = S_HO; end
        S_HO:   nst = S_FI;
        S_FI: if (stb) begin
          mag = (int'(pe) < 0) ? -int'(pe) : int'(pe);
          eff = (tmo == 0) ? 200 : int'(tmo);
          if (mag < int'(thr) && m_good == LOCKN - 1) begin
            nst = S_TR; m_good = 0; m_sym = 0;
          end else if (m_sym + 1 >= eff) begin
            nst = S_CO; m_good = 0; m_sym = 0;
          end else begin
            m_good = (mag < int'(thr)) ? m_good + 1 : 0;
            m_sym  = m_sym + 1;
          end
        end
        S_TR: if (stb) begin
          d = longint'(li) - m_prev;
          if (d < 0) d = -d;
          if (d > PI) begin
            nst = S_RE;
            if (m_cnt < CMAX) m_cnt = m_cnt + 1;
          end
        end
        S_RE:   nst = S_CO;
        default: nst = S_IDLE;
      endcase
      if (smp) m_prev = longint'(li);
      m_st = nst;
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!finished) begin
      chk("R2", "coarse_en", coarse_en, m_st == S_CO);
      chk("R3", "fine_load", fine_load, m_st == S_HO);
      chk("R3", "load_val", load_val, m_est);
      chk("R4", "fine_en", fine_en, (m_st == S_FI) || (m_st == S_TR));
      chk("R5", "locked", locked, m_st == S_TR);
      chk("R8", "slip", slip, m_st == S_RE);
      chk("R9", "slip_cnt", slip_cnt, m_cnt);
    end
  end

  // drive inputs for one clock; returns at the next falling edge
  task automatic cyc(input logic s, input logic dn, input logic b,
                     input logic signed [PH_W-1:0] p, input logic signed [INT_W-1:0] l);
    start = s; done = dn; stb = b; pe = p; li = l;
    @(negedge clk);
  endtask

  logic signed [INT_W-1:0] li_cur = 20'sd1000;

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b0, 16'sd0, li_cur);
  endtask

  task automatic sym(input logic signed [PH_W-1:0] p, input bit gap);
    li_cur = li_cur + 20'sd3;
    cyc(1'b0, 1'b0, 1'b1, p, li_cur);
    if (gap) idle(1);
  endtask

  task automatic acquire(input logic [INT_W-1:0] e);
    est = e;
    cyc(1'b0, 1'b1, 1'b0, 16'sd0, li_cur);
    idle(1);
  endtask

  task automatic lock_run(input bit gap);
    for (int i = 0; i < LOCKN; i++) sym(16'sd20, gap);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(4);
    // R1: outputs quiet after reset
    chk("R1", "reset coarse_en", coarse_en, 0);
    chk("R1", "reset fine_en", fine_en, 0);
    chk("R1", "reset locked", locked, 0);
    chk("R1", "reset slip_cnt", slip_cnt, 0);
    chk("R1", "reset load", fine_load, 0);

    // R3: coarse_done while idle is ignored
    est = 20'h0BEEF;
    cyc(1'b0, 1'b1, 1'b0, 16'sd0, li_cur);
    chk("R3", "done ignored in idle", fine_load, 0);
    chk("R2", "done ignored in idle", coarse_en, 0);
    // R2: start from idle
    cyc(1'b1, 1'b0, 1'b0, 16'sd0, li_cur);
    chk("R2", "coarse_en after start", coarse_en, 1);
    cyc(1'b1, 1'b0, 1'b0, 16'sd0, li_cur);
    chk("R2", "second start ignored", coarse_en, 1);
    // R3: handoff
    est = 20'h2A5A5;
    cyc(1'b0, 1'b1, 1'b0, 16'sd0, li_cur);
    chk("R3", "load strobe", fine_load, 1);
    chk("R3", "load value", load_val, 20'h2A5A5);
    chk("R3", "coarse off at load", coarse_en, 0);
    idle(1);
    chk("R4", "fine_en after load", fine_en, 1);
    chk("R3", "load one cycle", fine_load, 0);

    // R5: threshold edge and most negative code break the run
    thr = 16'd100;
    for (int i = 0; i < 20; i++) sym((i % 2) ? 16'sd99 : -16'sd99, 1'b1);
    sym(16'sd100, 1'b1);
    for (int i = 0; i < 31; i++) sym(16'sd5, 1'b0);
    sym(-16'sd32768, 1'b0);
    chk("R5", "most negative code not good", locked, 0);
    for (int i = 0; i < 31; i++) sym(-16'sd7, 1'b1);
    chk("R5", "no lock at 31", locked, 0);
    sym(16'sd0, 1'b0);
    chk("R5", "lock at 32", locked, 1);

    // R2: start while tracking is ignored
    cyc(1'b1, 1'b0, 1'b0, 16'sd0, li_cur);
    chk("R2", "start ignored in track", locked, 1);
    // R8: exact pi steps are not slips
    li_cur = li_cur + 20'sd32768;
    cyc(1'b0, 1'b0, 1'b1, 16'sd0, li_cur);
    chk("R8", "step +pi no slip", slip, 0);
    li_cur = li_cur - 20'sd32768;
    cyc(1'b0, 1'b0, 1'b1, 16'sd0, li_cur);
    chk("R8", "step -pi no slip", locked, 1);
    idle(2);
    li_cur = li_cur + 20'sd32769;
    cyc(1'b0, 1'b0, 1'b1, 16'sd0, li_cur);
    chk("R8", "slip pulse", slip, 1);
    chk("R8", "lock dropped", locked, 0);
    chk("R9", "count one", slip_cnt, 1);
    idle(1);
    chk("R8", "reacquire coarse", coarse_en, 1);
    chk("R8", "slip one cycle", slip, 0);

    // R6: timeout of 10 symbols
    tmo = 16'd10;
    acquire(20'hF0F0F);
    for (int i = 0; i < 9; i++) sym(16'sd500, 1'b1);
    chk("R6", "still fine at 9", fine_en, 1);
    sym(16'sd500, 1'b0);
    chk("R6", "timeout to coarse", coarse_en, 1);
    // R6: tie between lock and timeout
    tmo = 16'd32;
    acquire(20'h00123);
    lock_run(1'b0);
    chk("R6", "lock wins tie", locked, 1);
    li_cur = li_cur - 20'sd40000;
    cyc(1'b0, 1'b0, 1'b1, 16'sd0, li_cur);
    chk("R8", "negative slip", slip, 1);
    chk("R9", "count two", slip_cnt, 2);
    idle(1);

    // R7: zero timeout means 200
    tmo = '0;
    acquire(20'h55555);
    for (int i = 0; i < 199; i++) sym(16'sd300, 1'b0);
    chk("R7", "still fine at 199", fine_en, 1);
    sym(16'sd300, 1'b0);
    chk("R7", "timeout at 200", coarse_en, 1);

    // R9: saturation
    for (int k = 0; k < CMAX + 2; k++) begin
      acquire(20'(k));
      lock_run(1'b0);
      li_cur = li_cur + 20'sd50000;
      cyc(1'b0, 1'b0, 1'b1, 16'sd0, li_cur);
      idle(1);
    end
    chk("R9", "count saturated", slip_cnt, CMAX);

    idle(3);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nfail++;
      $display("FAIL watchdog: actual still running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

endmodule